// File: doc/BRIEF.md
# Triggered Register-Write Replay Engine

This block is a bus master that plays back a stored list of register writes. The list sits in memory as a run of 8-byte descriptors. In each descriptor the first 32-bit word is the absolute target register address and the second word is the value to store there. Software gives the engine the byte address of the first descriptor, the byte address of the final byte of the list, and a trigger selection. When the selected event fires, the engine walks the list, fetching each descriptor through a memory read port and issuing it as one write on a register write port.

The typical use is display programming that must land in the blanking interval. Software prepares the list ahead of time and arms the engine on a vertical sync pulse. The register updates are then applied in hardware the next time sync occurs. The engine returns to idle after the final write and is armed again for the next event. All three data paths use valid/ready handshakes. A request or a write stays presented, with its address and data frozen, until the other side takes it. The engine accepts a memory response only while it is waiting for one. Configuration and status are plain level signals.

Top module: `regwr_replay`

## Requirements
- R1: For each descriptor at byte address P, the engine reads the word at P, then the word at P+4, and then issues one register write whose address is the first word and whose data is the second. Register addresses come only from the list and are never stepped by the engine.
- R2: A replay issues exactly (last-first+1)/8 writes, in list order, stepping P by 8 from `list_first`. Lists of up to 4096 bytes (512 descriptors) are accepted.
- R3: `trig_sel` encodings: 2'b01 starts on a `vsync` pulse, 2'b10 starts on a `sw_kick` pulse, and 2'b00 and 2'b11 mean stopped, so no event starts a replay. An event that does not match the selected source has no effect.
- R4: A selected event that arrives while `busy` is high, including the cycle in which the final write completes, does not restart the list and sets `pending`. `pending` clears when a valid replay starts or on soft reset.
- R5: If `list_last` < `list_first`, or the length is not a multiple of 8, or the length exceeds 4096 bytes, a selected event issues no memory request and no write, leaves `busy` low, and sets `cfg_err` in the next cycle. `cfg_err` clears when a valid replay starts or on soft reset.
- R6: A register write holds `reg_wr_valid`, `reg_wr_addr` and `reg_wr_data` steady until `reg_wr_ready`. No memory request is presented while a write is outstanding.
- R7: A memory request holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready`.
- R8: `busy` rises in the cycle after an accepted event and falls in the cycle after the final write handshake. While `busy` is low the engine presents no memory request and no write.
- R9: `soft_reset` high at a clock edge returns the engine to idle. After that edge `busy`, `pending`, `cfg_err`, `mem_req_valid` and `reg_wr_valid` are low, and a later replay runs normally.
- R10: Selecting a stop code during a replay ends it once the write in progress completes, with no further fetch.
- R11: After a replay finishes, the next selected event replays the list again from `list_first`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_reset | input | 1 | Synchronous return to idle; clears status |
| trig_sel | input | 2 | Trigger selection (01 sync, 10 kick, 00/11 stopped) |
| vsync | input | 1 | Vertical sync event pulse |
| sw_kick | input | 1 | Software start pulse |
| list_first | input | AW | Byte address of the first descriptor |
| list_last | input | AW | Byte address of the final byte of the list |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine waits for read data |
| mem_rsp_data | input | 32 | Read data word |
| reg_wr_valid | output | 1 | Register write valid |
| reg_wr_ready | input | 1 | Register bus accepts the write |
| reg_wr_addr | output | RAW | Target register address |
| reg_wr_data | output | 32 | Value to write |
| busy | output | 1 | Replay in progress |
| pending | output | 1 | An event was dropped while busy |
| cfg_err | output | 1 | Last event saw an invalid list |

## Verification
The critical coincidence is a new sync event that lands in the same edge as the handshake of the final write. At that edge the engine is still busy, so the event must be dropped and flagged rather than start a second pass. The bench provokes this by holding the register port not-ready on the last descriptor of a list, then raising ready and pulsing `vsync` in one and the same cycle. It then expects `pending` high, `busy` low, exactly the listed writes, and no memory request in the cycles that follow. The same check is repeated in a weaker form with a soft reset arriving just after a dropped event, where the reset must clear the flag.

// File: rtl/regwr_replay_pkg.sv
package regwr_replay_pkg;

  // trigger selection codes
  typedef enum logic [1:0] {
    TRIG_OFF   = 2'b00,
    TRIG_VSYNC = 2'b01,
    TRIG_KICK  = 2'b10,
    TRIG_OFF2  = 2'b11
  } trig_e;

  // walker states
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_REQ_A,
    WS_RSP_A,
    WS_REQ_D,
    WS_RSP_D,
    WS_WRITE
  } walk_e;

  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/rwr_trigger.sv
module rwr_trigger
  import regwr_replay_pkg::*;
(
  input  logic [1:0] trig_sel,
  input  logic       vsync,
  input  logic       sw_kick,
  output logic       fire,
  output logic       halted
);

  trig_e sel;

  always_comb begin
    sel = trig_e'(trig_sel);
    unique case (sel)
      TRIG_VSYNC: begin fire = vsync;   halted = 1'b0; end
      TRIG_KICK:  begin fire = sw_kick; halted = 1'b0; end
      default:    begin fire = 1'b0;    halted = 1'b1; end
    endcase
  end

endmodule

// File: rtl/rwr_list_check.sv
module rwr_list_check
  import regwr_replay_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned MAX_DESC = 512
) (
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic          list_ok
);

  localparam int unsigned MAX_BYTES = MAX_DESC * DESC_BYTES;
  localparam int unsigned ALIGN_W   = $clog2(DESC_BYTES);

  logic [AW:0] span;
  logic        ordered, aligned, fits;

  always_comb begin
    span    = {1'b0, last} - {1'b0, first} + (AW+1)'(1);
    ordered = (last >= first);
    aligned = (span[ALIGN_W-1:0] == '0);
    fits    = (span <= (AW+1)'(MAX_BYTES));
    list_ok = ordered && aligned && fits;
  end

endmodule

// File: rtl/rwr_walker.sv
module rwr_walker
  import regwr_replay_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned RAW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_reset,
  input  logic           go,
  input  logic           halt_req,
  input  logic [AW-1:0]  first,
  input  logic [AW-1:0]  last,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  output logic           mem_rsp_ready,
  input  logic [31:0]    mem_rsp_data,
  output logic           reg_wr_valid,
  input  logic           reg_wr_ready,
  output logic [RAW-1:0] reg_wr_addr,
  output logic [31:0]    reg_wr_data,
  output logic           active
);

  localparam logic [AW-1:0] STEP     = AW'(DESC_BYTES);
  localparam logic [AW-1:0] DATA_OFS = AW'(WORD_BYTES);
  localparam logic [AW-1:0] TAIL_OFS = AW'(DESC_BYTES - 1);

  walk_e          st;
  logic [AW-1:0]  ptr, stop_at;
  logic [RAW-1:0] tgt_q;
  logic [31:0]    val_q;
  logic           at_tail;

  assign at_tail       = ((ptr + TAIL_OFS) == stop_at);
  assign mem_req_valid = (st == WS_REQ_A) || (st == WS_REQ_D);
  assign mem_req_addr  = (st == WS_REQ_D) ? (ptr + DATA_OFS) : ptr;
  assign mem_rsp_ready = (st == WS_RSP_A) || (st == WS_RSP_D);
  assign reg_wr_valid  = (st == WS_WRITE);
  assign reg_wr_addr   = tgt_q;
  assign reg_wr_data   = val_q;
  assign active        = (st != WS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= WS_IDLE;
      ptr     <= '0;
      stop_at <= '0;
      tgt_q   <= '0;
      val_q   <= '0;
    end else if (soft_reset) begin
      st <= WS_IDLE;
    end else begin
      unique case (st)
        WS_IDLE:
          if (go) begin
            ptr     <= first;
            stop_at <= last;
            st      <= WS_REQ_A;
          end
        WS_REQ_A:
          if (mem_req_ready) st <= WS_RSP_A;
        WS_RSP_A:
          if (mem_rsp_valid) begin
            tgt_q <= mem_rsp_data[RAW-1:0];
            st    <= WS_REQ_D;
          end
        WS_REQ_D:
          if (mem_req_ready) st <= WS_RSP_D;
        WS_RSP_D:
          if (mem_rsp_valid) begin
            val_q <= mem_rsp_data;
            st    <= WS_WRITE;
          end
        WS_WRITE:
          if (reg_wr_ready) begin
            if (at_tail || halt_req) begin
              st <= WS_IDLE;
            end else begin
              ptr <= ptr + STEP;
              st  <= WS_REQ_A;
            end
          end
        default: st <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/regwr_replay.sv
module regwr_replay
  import regwr_replay_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned RAW      = 32,
  parameter int unsigned MAX_DESC = 512
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_reset,
  input  logic [1:0]     trig_sel,
  input  logic           vsync,
  input  logic           sw_kick,
  input  logic [AW-1:0]  list_first,
  input  logic [AW-1:0]  list_last,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  output logic           mem_rsp_ready,
  input  logic [31:0]    mem_rsp_data,
  output logic           reg_wr_valid,
  input  logic           reg_wr_ready,
  output logic [RAW-1:0] reg_wr_addr,
  output logic [31:0]    reg_wr_data,
  output logic           busy,
  output logic           pending,
  output logic           cfg_err
);

  logic fire, halted, list_ok, launch, active;

  rwr_trigger u_trig (
    .trig_sel (trig_sel),
    .vsync    (vsync),
    .sw_kick  (sw_kick),
    .fire     (fire),
    .halted   (halted)
  );

  rwr_list_check #(.AW(AW), .MAX_DESC(MAX_DESC)) u_chk_list (
    .first   (list_first),
    .last    (list_last),
    .list_ok (list_ok)
  );

  assign launch = fire && !active && list_ok;

  rwr_walker #(.AW(AW), .RAW(RAW)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_reset    (soft_reset),
    .go            (launch),
    .halt_req      (halted),
    .first         (list_first),
    .last          (list_last),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .reg_wr_valid  (reg_wr_valid),
    .reg_wr_ready  (reg_wr_ready),
    .reg_wr_addr   (reg_wr_addr),
    .reg_wr_data   (reg_wr_data),
    .active        (active)
  );

  assign busy = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cfg_err <= 1'b0;
    end else if (soft_reset) begin
      pending <= 1'b0;
      cfg_err <= 1'b0;
    end else if (fire) begin
      if (active) begin
        pending <= 1'b1;
      end else begin
        cfg_err <= !list_ok;
        if (list_ok) pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rwr_chk.sv
module rwr_chk #(
  parameter int unsigned AW  = 32,
  parameter int unsigned RAW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           soft_reset,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [AW-1:0]  mem_req_addr,
  input logic           reg_wr_valid,
  input logic           reg_wr_ready,
  input logic [RAW-1:0] reg_wr_addr,
  input logic [31:0]    reg_wr_data,
  input logic           busy,
  input logic           pending,
  input logic           cfg_err
);

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid && !reg_wr_ready && !soft_reset |=>
      reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data));

  // R6
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |-> !mem_req_valid);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !soft_reset |=>
      mem_req_valid && $stable(mem_req_addr));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !reg_wr_valid);

  // R9
  sreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !busy && !pending && !cfg_err);

  // R5
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> !busy);

  // R4
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(busy));

endmodule

bind regwr_replay rwr_chk #(.AW(AW), .RAW(RAW)) u_rwr_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_reset    (soft_reset),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .reg_wr_valid  (reg_wr_valid),
  .reg_wr_ready  (reg_wr_ready),
  .reg_wr_addr   (reg_wr_addr),
  .reg_wr_data   (reg_wr_data),
  .busy          (busy),
  .pending       (pending),
  .cfg_err       (cfg_err)
);

// File: tb/regwr_replay_test.sv
`timescale 1ns/1ps
module regwr_replay_test;

  localparam int AW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, soft_reset = 1'b0, vsync = 1'b0, sw_kick = 1'b0;
  logic [1:0]    trig_sel = 2'b00;
  logic [AW-1:0] list_first = '0, list_last = '0;
  logic          mem_req_valid, mem_req_ready, mem_rsp_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   mem_rsp_data = '0;
  logic          reg_wr_valid, reg_wr_ready;
  logic [31:0]   reg_wr_addr, reg_wr_data;
  logic          busy, pending, cfg_err;

  regwr_replay uut (
    .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .trig_sel(trig_sel),
    .vsync(vsync), .sw_kick(sw_kick), .list_first(list_first), .list_last(list_last),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .busy(busy), .pending(pending), .cfg_err(cfg_err)
  );

  int checks = 0, errors = 0, wr_seen = 0, req_seen = 0, r7_viol = 0, cyc = 0;
  logic [63:0] sb[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] d_addr(input int i);
    return 32'hC000_0000 ^ (i * 32'h0001_0104);
  endfunction
  function automatic logic [31:0] d_data(input int i);
    return i * 32'h9E37_79B9 + 32'd5;
  endfunction

  logic [31:0] mem [0:1023];
  initial for (int i = 0; i < 512; i++) begin
    mem[2*i]   = d_addr(i);
    mem[2*i+1] = d_data(i);
  end

  // stall pattern for both ports
  logic [7:0] lf = 8'hA5;
  logic hold_wr = 1'b0, go_wr = 1'b0;
  always @(posedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  assign mem_req_ready = lf[0] | lf[3];
  assign reg_wr_ready  = go_wr ? 1'b1 : (hold_wr ? 1'b0 : (lf[1] | lf[6]));

  // memory model
  always @(posedge clk) begin
    if (soft_reset) mem_rsp_valid <= 1'b0;
    else begin
      if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[11:2]];
        req_seen++;
      end
    end
  end

  // scoreboard monitor, also tracks request stability (R7)
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && !soft_reset && (!mem_req_valid || mem_req_addr != prev_addr)) r7_viol++;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (reg_wr_valid && reg_wr_ready) begin
        wr_seen++;
        if (sb.size() == 0) chk(1'b0, "R2 unexpected write", {reg_wr_addr, reg_wr_data}, 64'h0);
        else begin
          logic [63:0] e;
          e = sb.pop_front();
          chk({reg_wr_addr, reg_wr_data} == e, "R1 write addr/data", {reg_wr_addr, reg_wr_data}, e);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expect_list(input int idx, input int n);
    for (int i = 0; i < n; i++) sb.push_back({d_addr(idx + i), d_data(idx + i)});
  endtask
  task automatic set_list(input int idx, input int n);
    list_first = AW'(idx * 8);
    list_last  = AW'(idx * 8 + n * 8 - 1);
  endtask
  task automatic pulse(input bit kick);
    @(posedge clk); #1;
    if (kick) sw_kick = 1'b1; else vsync = 1'b1;
    @(posedge clk); #1;
    sw_kick = 1'b0; vsync = 1'b0;
  endtask
  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask
  task automatic quiet(input string tag);
    int r0;
    r0 = req_seen;
    repeat (6) @(negedge clk);
    chk(!busy && req_seen == r0, tag, {31'b0, busy, 32'(req_seen)}, {32'b0, 32'(r0)});
  endtask
  task automatic run(input int idx, input int n, input bit kick, input string tag);
    int w0;
    w0 = wr_seen;
    set_list(idx, n);
    expect_list(idx, n);
    pulse(kick);
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after event", busy, 1);
    wait_idle();
    chk(wr_seen - w0 == n && sb.size() == 0, tag, wr_seen - w0, n);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !pending && !cfg_err && !mem_req_valid && !reg_wr_valid,
        "R9 reset state", {busy, pending, cfg_err, mem_req_valid, reg_wr_valid}, 0);

    // R1 R2 R3: sync trigger, stalls on both ports (R7)
    trig_sel = 2'b01;
    run(4, 3, 1'b0, "R2 sync replay count");
    // R11: re-armed, same list again
    run(4, 3, 1'b0, "R11 second replay count");

    // R3: mismatched or stopped sources
    set_list(4, 3);
    pulse(1'b1);           quiet("R3 kick ignored under sync code");
    trig_sel = 2'b00; pulse(1'b0); quiet("R3 stop code ignores vsync");
    trig_sel = 2'b11; pulse(1'b0); pulse(1'b1); quiet("R3 code 11 ignores events");
    trig_sel = 2'b10;
    run(32, 2, 1'b1, "R3 kick replay count");

    // R4: event mid-replay is dropped and flagged
    trig_sel = 2'b01;
    begin
      int w0, r0;
      w0 = wr_seen;
      set_list(10, 4); expect_list(10, 4);
      pulse(1'b0);
      repeat (3) @(negedge clk);
      pulse(1'b0);
      @(negedge clk);
      chk(pending == 1'b1, "R4 pending after busy event", pending, 1);
      wait_idle();
      chk(wr_seen - w0 == 4, "R4 no restart", wr_seen - w0, 4);
      quiet("R4 stays idle after drop");
      run(10, 1, 1'b0, "R4 next run count");
      chk(pending == 1'b0, "R4 pending cleared by start", pending, 0);
    end

    // R4: event coinciding with the final write handshake
    begin
      int w0, r0;
      w0 = wr_seen;
      set_list(20, 2); expect_list(20, 2);
      pulse(1'b0);
      do @(negedge clk); while (wr_seen != w0 + 1);
      @(posedge clk); #1 hold_wr = 1'b1;
      do @(negedge clk); while (!reg_wr_valid);
      @(posedge clk); #1 hold_wr = 1'b0; go_wr = 1'b1; vsync = 1'b1;
      @(posedge clk); #1 go_wr = 1'b0; vsync = 1'b0;
      @(negedge clk);
      chk(pending && !busy, "R4 coincident event dropped", {pending, busy}, 2'b10);
      r0 = req_seen;
      repeat (6) @(negedge clk);
      chk(req_seen == r0 && wr_seen - w0 == 2, "R4 coincident no restart", wr_seen - w0, 2);
    end

    // R5: invalid lists
    list_first = 32'h200; list_last = 32'h1FF; pulse(1'b0); @(negedge clk);
    chk(cfg_err && !busy, "R5 last below first", {cfg_err, busy}, 2'b10);
    quiet("R5 no fetch, reversed");
    list_first = 32'h200; list_last = 32'h20B; pulse(1'b0); @(negedge clk);
    chk(cfg_err && !busy, "R5 length 12", {cfg_err, busy}, 2'b10);
    quiet("R5 no fetch, length 12");
    list_first = 32'h0; list_last = 32'd4103; pulse(1'b0); @(negedge clk);
    chk(cfg_err && !busy, "R5 length 4104", {cfg_err, busy}, 2'b10);
    quiet("R5 no fetch, oversize");
    // R2 R5: exactly 4096 bytes is accepted and clears the error
    run(0, 512, 1'b0, "R2 full 512 descriptor list");
    chk(cfg_err == 1'b0, "R5 error cleared by valid start", cfg_err, 0);

    // R6: write held under back-pressure, no fetch meanwhile
    begin
      logic [63:0] snap;
      bit ok;
      set_list(40, 1); expect_list(40, 1);
      @(posedge clk); #1 hold_wr = 1'b1;
      pulse(1'b0);
      do @(negedge clk); while (!reg_wr_valid);
      snap = {reg_wr_addr, reg_wr_data};
      ok = 1'b1;
      repeat (5) begin
        @(negedge clk);
        if (!reg_wr_valid || mem_req_valid || {reg_wr_addr, reg_wr_data} != snap) ok = 1'b0;
      end
      chk(ok, "R6 write held", {reg_wr_addr, reg_wr_data}, snap);
      @(posedge clk); #1 hold_wr = 1'b0;
      wait_idle();
    end

    // R10: stop code mid-replay ends after current write
    begin
      int w0;
      w0 = wr_seen;
      set_list(50, 3); expect_list(50, 1);
      @(posedge clk); #1 hold_wr = 1'b1;
      pulse(1'b0);
      do @(negedge clk); while (!reg_wr_valid);
      @(posedge clk); #1 trig_sel = 2'b00; hold_wr = 1'b0;
      wait_idle();
      quiet("R10 no fetch after stop");
      chk(wr_seen - w0 == 1 && sb.size() == 0, "R10 one write then stop", wr_seen - w0, 1);
      trig_sel = 2'b01;
    end

    // R9: soft reset during a replay with a pending drop
    set_list(60, 3); expect_list(60, 3);
    pulse(1'b0);
    repeat (3) @(posedge clk);
    pulse(1'b0);
    @(posedge clk); #1 soft_reset = 1'b1;
    @(posedge clk); #1 soft_reset = 1'b0;
    @(negedge clk);
    chk(!busy && !pending && !cfg_err && !mem_req_valid && !reg_wr_valid,
        "R9 soft reset idle", {busy, pending, cfg_err, mem_req_valid, reg_wr_valid}, 0);
    sb.delete();
    run(60, 3, 1'b0, "R9 replay after soft reset");

    // R7: request held while stalled throughout
    chk(r7_viol == 0, "R7 request stable under stall", r7_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule